// File: doc/BRIEF.md
# Word FIFO to Byte-Stream Data Mover

This block sits between a 32-bit register-side data port and a byte-wide card data stream. A circular FIFO of 16 words buffers the data in between. Software sets a block byte size and then a block count. The block count write loads the remaining byte count with the product of the two. A command issue picks the direction. In the read direction, bytes from the card are packed into words, least significant byte first, and pushed into the FIFO. In the write direction, FIFO words are popped and sent to the card as four bytes, lowest byte first.

The mover sets three status bits: a data flag, a data interrupt and a block interrupt. Software clears them with a mask. It also keeps a debug word. The low nibble of that word holds a state code, and bits 8:4 hold the FIFO fill level seen at the end of each transfer step. A transfer step starts only after one of these events: a data-port access, a config write, a command issue or a block-count write. Once started, a step moves at most one byte per clock until it can no longer proceed. When a read step stops part way through a word, the partial word is flushed into the FIFO.

Top module: `wbm_mover`

## Requirements
- R1: After reset, status is 0, irq is 0, the debug word is 0x0000C60F, the remaining byte count is 0 and the FIFO is empty.
- R2: A debug write stores the written value, except that a low nibble of 0xF is stored as 0x0.
- R3: In the write direction, each FIFO word goes to the card as four bytes, bits 7:0 first. There is at most one byte per cycle on card_tx_byte while card_tx_valid is high, and each byte lowers the remaining count by one.
- R4: Each word popped for the card sets status bit 0 (data flag). It also sets status bit 8 (data interrupt) when the data-interrupt enable is set.
- R5: When the remaining count reaches zero, debug bits 3:0 become 0x1. In the write direction with the block-interrupt enable set, status bit 9 is also set. irq is high while any of status bits 10:8 is set.
- R6: In the read direction, a card byte is taken only while card_rx_ready is high, the count is nonzero and the FIFO is not full. Successive bytes fill bits 7:0, 15:8, 23:16 and 31:24. Each full word pushed sets status bit 0, plus bit 8 if the data-interrupt enable is set.
- R7: When a read step stops with a partly filled word, that word is pushed with its upper bytes zero. This push sets status bit 0 only, never bit 8.
- R8: The FIFO holds 16 words. A data-port write into a full FIFO is dropped. A data-port read returns the oldest word on dp_rdata the cycle after the request, or 0 with no change when the FIFO is empty.
- R9: At the end of each transfer step, debug bits 8:4 hold the FIFO fill level.
- R10: A block-count write loads the count with block count times block byte size. No byte moves until one of the trigger events occurs, even if the card becomes ready.
- R11: A status clear with a mask clears the status bits set in the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Config write strobe (a step trigger) |
| cfg_data_irq_en | input | 1 | Data-interrupt enable, stored on cfg_wr |
| cfg_blk_irq_en | input | 1 | Block-interrupt enable, stored on cfg_wr |
| cmd_go | input | 1 | Command issue (a step trigger) |
| cmd_dir | input | 1 | Direction stored on cmd_go: 1 read, 0 write |
| bsize_wr | input | 1 | Block byte size write strobe |
| bsize_wdata | input | BSIZE_W | Block byte size |
| blkcnt_wr | input | 1 | Block count write strobe, loads the count (a step trigger) |
| blkcnt_wdata | input | BLK_W | Block count |
| dp_wr | input | 1 | Data-port write: push a word (a step trigger) |
| dp_wdata | input | 32 | Word to push |
| dp_rd | input | 1 | Data-port read: pop a word (a step trigger) |
| dp_rdata | output | 32 | Popped word, valid the cycle after dp_rd |
| sts_clr | input | 1 | Status clear strobe |
| sts_clr_mask | input | 11 | Status bits to clear |
| status | output | 11 | Status: bit 0 data flag, bit 8 data irq, bit 9 block irq |
| irq | output | 1 | OR of status bits 10:8 |
| dbg_wr | input | 1 | Debug word write strobe |
| dbg_wdata | input | 32 | Debug word write value |
| dbg_q | output | 32 | Debug word: 3:0 state code, 8:4 FIFO fill level |
| card_rx_ready | input | 1 | Card has a byte available |
| card_rx_byte | input | 8 | Byte from the card |
| card_rx_take | output | 1 | Byte taken this cycle |
| card_tx_valid | output | 1 | Byte sent to the card this cycle |
| card_tx_byte | output | 8 | Byte to the card |
| bytes_left | output | BLK_W+BSIZE_W | Remaining byte count |

## Verification
A wrong pack lane or unpack order shows up as swapped bytes, either in the word read back on the data port or in the logged card byte stream. Both are compared as soon as a single step has run. A stuck or misdirected step-arm flag shows in two ways. Either bytes_left keeps moving after the card becomes ready with no trigger, or it stays at its loaded value after a trigger. Either case is visible within a few cycles. A wrong FIFO level shows in debug bits 8:4 at the next step end, and in the order or the zero value of the words drained after an overflow.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int LANES    = WORD_W / BYTE_W;
    localparam int LANE_W   = $clog2(LANES);
    localparam int STATUS_W = 11;

    // status bit positions
    localparam int ST_DATA_FLAG = 0;
    localparam int ST_DATA_IRQ  = 8;
    localparam int ST_BLK_IRQ   = 9;
    localparam int ST_IRQ_LO    = 8;
    localparam int ST_IRQ_HI    = 10;

    // debug word layout
    localparam logic [31:0] DBG_RESET      = 32'h0000_C60F;
    localparam int          DBG_FILL_LO    = 4;
    localparam int          DBG_FILL_W     = 5;
    localparam logic [3:0]  DBG_STATE_DATA = 4'h1;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic              valid;
        logic              full;
        logic [WORD_W-1:0] word;
    } word_push_t;

    function automatic logic [31:0] scrub_dbg(input logic [31:0] v);
        logic [31:0] r;
        r = v;
        if (v[3:0] == 4'hF) r[3:0] = 4'h0;
        return r;
    endfunction

endpackage

// File: rtl/wbm_ring.sv
module wbm_ring
    import wbm_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic              empty,
    output logic              full,
    output logic [$clog2(DEPTH):0] level_nxt
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
    logic [LW-1:0]     level_q;
    logic              push_ok, pop_ok;

    assign empty   = (level_q == '0);
    assign full    = (level_q == LW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr_q];

    always_comb begin
        level_nxt = level_q;
        if (push_ok) level_nxt = level_nxt + 1'b1;
        if (pop_ok)  level_nxt = level_nxt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
            level_q <= level_nxt;
        end
    end
endmodule

// File: rtl/wbm_packer.sv
module wbm_packer
    import wbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              flush,
    output word_push_t        push_o
);
    logic [LANE_W-1:0] lane_q;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] merged;
    logic              last_lane;

    assign last_lane = (lane_q == LANE_W'(LANES - 1));
    assign merged    = acc_q | (WORD_W'(byte_in) << (int'(lane_q) * BYTE_W));

    always_comb begin
        push_o.valid = (take && last_lane) || (flush && lane_q != '0);
        push_o.full  = take;
        push_o.word  = take ? merged : acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q <= '0;
            acc_q  <= '0;
        end else if (take) begin
            if (last_lane) begin
                lane_q <= '0;
                acc_q  <= '0;
            end else begin
                lane_q <= lane_q + 1'b1;
                acc_q  <= merged;
            end
        end else if (flush) begin
            lane_q <= '0;
            acc_q  <= '0;
        end
    end
endmodule

// File: rtl/wbm_unpacker.sv
module wbm_unpacker
    import wbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              clear,
    input  logic [WORD_W-1:0] head,
    output logic              pop,
    output logic              has_bytes,
    output logic [BYTE_W-1:0] tx_byte
);
    logic [WORD_W-BYTE_W-1:0] hold_q;
    logic [LANE_W-1:0]        left_q;

    assign has_bytes = (left_q != '0);
    assign pop       = step && !has_bytes;
    assign tx_byte   = has_bytes ? hold_q[BYTE_W-1:0] : head[BYTE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hold_q <= '0;
            left_q <= '0;
        end else if (step) begin
            if (!has_bytes) begin
                hold_q <= head[WORD_W-1:BYTE_W];
                left_q <= LANE_W'(LANES - 1);
            end else begin
                hold_q <= hold_q >> BYTE_W;
                left_q <= left_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/wbm_mover.sv
module wbm_mover
    import wbm_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int BLK_W      = 9,
    parameter int BSIZE_W    = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_wr,
    input  logic                     cfg_data_irq_en,
    input  logic                     cfg_blk_irq_en,
    input  logic                     cmd_go,
    input  logic                     cmd_dir,
    input  logic                     bsize_wr,
    input  logic [BSIZE_W-1:0]       bsize_wdata,
    input  logic                     blkcnt_wr,
    input  logic [BLK_W-1:0]         blkcnt_wdata,
    input  logic                     dp_wr,
    input  logic [31:0]              dp_wdata,
    input  logic                     dp_rd,
    output logic [31:0]              dp_rdata,
    input  logic                     sts_clr,
    input  logic [10:0]              sts_clr_mask,
    output logic [10:0]              status,
    output logic                     irq,
    input  logic                     dbg_wr,
    input  logic [31:0]              dbg_wdata,
    output logic [31:0]              dbg_q,
    input  logic                     card_rx_ready,
    input  logic [7:0]               card_rx_byte,
    output logic                     card_rx_take,
    output logic                     card_tx_valid,
    output logic [7:0]               card_tx_byte,
    output logic [BLK_W+BSIZE_W-1:0] bytes_left
);
    localparam int CNT_W = BLK_W + BSIZE_W;
    localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

    xfer_dir_e          dir_q;
    logic               data_irq_en_q, blk_irq_en_q;
    logic [BSIZE_W-1:0] bsize_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               armed_q;
    logic [STATUS_W-1:0] status_q;
    logic [31:0]        dbg_r;
    logic [31:0]        rdata_q;

    logic               trig, engine_free, rd_move, wr_move, move, step_end, done;
    logic               fifo_empty, fifo_full;
    logic [WORD_W-1:0]  fifo_head;
    logic [LVL_W-1:0]   level_nxt;
    word_push_t         pk_push;
    logic               up_pop, up_has, up_clear;
    logic [BYTE_W-1:0]  up_byte;

    assign trig        = dp_wr || dp_rd || cfg_wr || cmd_go || blkcnt_wr;
    assign engine_free = armed_q && !trig && (cnt_q != '0);
    assign rd_move     = engine_free && dir_q == DIR_READ && card_rx_ready && !fifo_full;
    assign wr_move     = engine_free && dir_q == DIR_WRITE && (up_has || !fifo_empty);
    assign move        = rd_move || wr_move;
    assign step_end    = armed_q && !trig && !move;
    assign done        = move && (cnt_q == CNT_W'(1));
    assign up_clear    = cmd_go || blkcnt_wr || done;

    wbm_ring #(.DEPTH(FIFO_DEPTH)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .push      (dp_wr || pk_push.valid),
        .push_data (dp_wr ? dp_wdata : pk_push.word),
        .pop       (dp_rd || up_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .level_nxt (level_nxt)
    );

    wbm_packer u_pack (
        .clk     (clk),
        .rst     (rst),
        .take    (rd_move),
        .byte_in (card_rx_byte),
        .flush   (step_end && dir_q == DIR_READ),
        .push_o  (pk_push)
    );

    wbm_unpacker u_unpack (
        .clk       (clk),
        .rst       (rst),
        .step      (wr_move),
        .clear     (up_clear),
        .head      (fifo_head),
        .pop       (up_pop),
        .has_bytes (up_has),
        .tx_byte   (up_byte)
    );

    // control registers and byte count
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q         <= DIR_WRITE;
            data_irq_en_q <= 1'b0;
            blk_irq_en_q  <= 1'b0;
            bsize_q       <= '0;
            cnt_q         <= '0;
            armed_q       <= 1'b0;
            rdata_q       <= '0;
        end else begin
            if (cmd_go) dir_q <= xfer_dir_e'(cmd_dir);
            if (cfg_wr) begin
                data_irq_en_q <= cfg_data_irq_en;
                blk_irq_en_q  <= cfg_blk_irq_en;
            end
            if (bsize_wr) bsize_q <= bsize_wdata;
            if (blkcnt_wr)  cnt_q <= CNT_W'(blkcnt_wdata) * CNT_W'(bsize_q);
            else if (move)  cnt_q <= cnt_q - 1'b1;
            if (trig)          armed_q <= 1'b1;
            else if (step_end) armed_q <= 1'b0;
            if (dp_rd) rdata_q <= fifo_empty ? '0 : fifo_head;
        end
    end

    // status register: sets win over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            logic [STATUS_W-1:0] nxt;
            nxt = sts_clr ? (status_q & ~sts_clr_mask) : status_q;
            if (pk_push.valid || up_pop) nxt[ST_DATA_FLAG] = 1'b1;
            if (((pk_push.valid && pk_push.full) || up_pop) && data_irq_en_q)
                nxt[ST_DATA_IRQ] = 1'b1;
            if (done && dir_q == DIR_WRITE && blk_irq_en_q)
                nxt[ST_BLK_IRQ] = 1'b1;
            status_q <= nxt;
        end
    end

    // debug word: software write wins over engine updates
    always_ff @(posedge clk) begin
        if (rst) begin
            dbg_r <= DBG_RESET;
        end else if (dbg_wr) begin
            dbg_r <= scrub_dbg(dbg_wdata);
        end else begin
            if (done) dbg_r[3:0] <= DBG_STATE_DATA;
            if (step_end)
                dbg_r[DBG_FILL_LO +: DBG_FILL_W] <= DBG_FILL_W'(level_nxt);
        end
    end

    assign dp_rdata      = rdata_q;
    assign status        = status_q;
    assign irq           = |status_q[ST_IRQ_HI:ST_IRQ_LO];
    assign dbg_q         = dbg_r;
    assign card_rx_take  = rd_move;
    assign card_tx_valid = wr_move;
    assign card_tx_byte  = up_byte;
    assign bytes_left    = cnt_q;

endmodule

// File: rtl/wbm_mover_chk.sv
module wbm_mover_chk #(
    parameter int CNT_W = 25
) (
    input logic             clk,
    input logic             rst,
    input logic             card_tx_valid,
    input logic             card_rx_take,
    input logic             card_rx_ready,
    input logic             blkcnt_wr,
    input logic [CNT_W-1:0] bytes_left,
    input logic             dbg_wr,
    input logic [31:0]      dbg_wdata,
    input logic [31:0]      dbg_q,
    input logic [10:0]      status
);
    // R3
    tx_count_chk: assert property (@(posedge clk) disable iff (rst)
        (card_tx_valid && !blkcnt_wr) |=> bytes_left == $past(bytes_left) - 1'b1);

    // R6
    rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        card_rx_take |-> (card_rx_ready && bytes_left != '0));

    // R3
    one_dir_chk: assert property (@(posedge clk) disable iff (rst)
        !(card_tx_valid && card_rx_take));

    // R2
    dbg_nibble_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_wr && dbg_wdata[3:0] == 4'hF) |=> dbg_q[3:0] == 4'h0);

    // R5
    blk_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[9]) |-> bytes_left == '0);

    // R10
    idle_count_chk: assert property (@(posedge clk) disable iff (rst)
        (bytes_left == '0 && !blkcnt_wr) |=> bytes_left == '0);
endmodule

bind wbm_mover wbm_mover_chk #(.CNT_W(BLK_W + BSIZE_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .card_tx_valid (card_tx_valid),
    .card_rx_take  (card_rx_take),
    .card_rx_ready (card_rx_ready),
    .blkcnt_wr     (blkcnt_wr),
    .bytes_left    (bytes_left),
    .dbg_wr        (dbg_wr),
    .dbg_wdata     (dbg_wdata),
    .dbg_q         (dbg_q),
    .status        (status)
);

// File: tb/wbm_mover_tb_top.sv
module wbm_mover_tb_top;
    localparam int BLK_W   = 9;
    localparam int BSIZE_W = 16;
    localparam int CNT_W   = BLK_W + BSIZE_W;

    localparam logic [31:0] WR_VEC [4] = '{32'h4433_2211, 32'hA5B6_C7D8,
                                           32'h0F1E_2D3C, 32'h8001_7F02};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wr = 0, cfg_data_irq_en = 0, cfg_blk_irq_en = 0;
    logic cmd_go = 0, cmd_dir = 0;
    logic bsize_wr = 0;  logic [BSIZE_W-1:0] bsize_wdata = '0;
    logic blkcnt_wr = 0; logic [BLK_W-1:0] blkcnt_wdata = '0;
    logic dp_wr = 0, dp_rd = 0;
    logic [31:0] dp_wdata = '0, dp_rdata;
    logic sts_clr = 0; logic [10:0] sts_clr_mask = '0, status;
    logic irq;
    logic dbg_wr = 0; logic [31:0] dbg_wdata = '0, dbg_q;
    logic card_rx_ready = 0, card_rx_take, card_tx_valid;
    logic [7:0] card_rx_byte, card_tx_byte;
    logic [CNT_W-1:0] bytes_left;

    int n_run = 0, n_fail = 0;
    int rx_idx = 0;
    int txn = 0;
    logic [7:0] txlog [64];
    logic finished = 0;

    always #4 clk = ~clk;

    assign card_rx_byte = 8'(8'h10 + rx_idx);

    always @(posedge clk) begin
        if (card_rx_take) rx_idx <= rx_idx + 1;
        if (card_tx_valid) begin
            txlog[txn % 64] <= card_tx_byte;
            txn <= txn + 1;
        end
    end

    wbm_mover #(.BLK_W(BLK_W), .BSIZE_W(BSIZE_W)) dut_i (.*);

    task automatic tick(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(logic di, logic bi);
        cfg_wr = 1; cfg_data_irq_en = di; cfg_blk_irq_en = bi; tick(); cfg_wr = 0;
    endtask
    task automatic go(logic dir);
        cmd_go = 1; cmd_dir = dir; tick(); cmd_go = 0;
    endtask
    task automatic set_bsize(int v);
        bsize_wr = 1; bsize_wdata = BSIZE_W'(v); tick(); bsize_wr = 0;
    endtask
    task automatic set_blk(int v);
        blkcnt_wr = 1; blkcnt_wdata = BLK_W'(v); tick(); blkcnt_wr = 0;
    endtask
    task automatic dp_write(logic [31:0] v);
        dp_wr = 1; dp_wdata = v; tick(); dp_wr = 0;
    endtask
    task automatic dp_read(output logic [31:0] v);
        dp_rd = 1; tick(); dp_rd = 0; v = dp_rdata;
    endtask
    task automatic clr_all();
        sts_clr = 1; sts_clr_mask = 11'h7FF; tick(); sts_clr = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int base, b0;
        tick(3);
        rst = 0;
        tick();

        // R1 reset state
        check("R1 status", 32'(status), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 dbg", dbg_q, 32'h0000_C60F);
        check("R1 count", 32'(bytes_left), 0);
        dp_read(v);
        check("R1 R8 empty pop", v, 0);

        // R2 debug nibble scrub
        dbg_wr = 1; dbg_wdata = 32'h1234_567F; tick(); dbg_wr = 0;
        check("R2 scrub", dbg_q, 32'h1234_5670);
        dbg_wr = 1; dbg_wdata = 32'h0000_C60A; tick(); dbg_wr = 0;
        check("R2 plain", dbg_q, 32'h0000_C60A);

        // R3 R4 R5 write direction, vectors walked from the table
        set_cfg(1, 1);
        set_bsize(4);
        go(1'b0);
        set_blk(4);
        check("R10 product", 32'(bytes_left), 16);
        base = txn;
        for (int i = 0; i < 4; i++) begin
            dp_write(WR_VEC[i]);
            tick(6);
        end
        check("R3 byte total", 32'(txn - base), 16);
        for (int i = 0; i < 4; i++) begin
            check("R3 lsb-first word",
                  {txlog[(base + 4*i + 3) % 64], txlog[(base + 4*i + 2) % 64],
                   txlog[(base + 4*i + 1) % 64], txlog[(base + 4*i) % 64]}, WR_VEC[i]);
        end
        check("R4 R5 status", 32'(status), 32'h301);
        check("R5 irq", 32'(irq), 1);
        check("R5 state", 32'(dbg_q[3:0]), 1);
        check("R9 fill", 32'(dbg_q[8:4]), 0);
        check("R3 count", 32'(bytes_left), 0);

        // R11 clear
        clr_all();
        check("R11 cleared", 32'(status), 0);
        check("R11 irq low", 32'(irq), 0);

        // R4 R5 with both enables off
        set_cfg(0, 0);
        set_blk(1);
        dp_write(32'hCAFE_F00D);
        tick(6);
        check("R4 R5 no irq bits", 32'(status), 32'h001);
        check("R3 last byte", 32'(txlog[(txn - 1) % 64]), 32'hCA);
        clr_all();

        // R6 R7 read direction, 6 bytes => one word plus partial
        set_cfg(1, 0);
        card_rx_ready = 1;
        set_bsize(6);
        go(1'b1);
        b0 = rx_idx;
        set_blk(1);
        tick(10);
        check("R9 fill two", 32'(dbg_q[8:4]), 2);
        check("R6 status", 32'(status), 32'h101);
        check("R5 read state", 32'(dbg_q[3:0]), 1);
        dp_read(v);
        check("R6 packed word", v, {8'(8'h13 + b0), 8'(8'h12 + b0), 8'(8'h11 + b0), 8'(8'h10 + b0)});
        dp_read(v);
        check("R7 partial word", v, {16'h0, 8'(8'h15 + b0), 8'(8'h14 + b0)});
        dp_read(v);
        check("R8 underflow zero", v, 0);
        tick(2);
        check("R9 fill drained", 32'(dbg_q[8:4]), 0);

        // R7 partial only: no data irq
        clr_all();
        set_bsize(2);
        b0 = rx_idx;
        set_blk(1);
        tick(6);
        check("R7 flag only", 32'(status), 32'h001);
        dp_read(v);
        check("R7 two bytes", v, {16'h0, 8'(8'h11 + b0), 8'(8'h10 + b0)});

        // R10 no movement without a trigger
        card_rx_ready = 0;
        set_bsize(4);
        set_blk(1);
        tick(5);
        check("R6 stalled", 32'(bytes_left), 4);
        card_rx_ready = 1;
        b0 = rx_idx;
        tick(5);
        check("R10 no trigger", 32'(bytes_left), 4);
        set_cfg(1, 0);
        tick(8);
        check("R10 after trigger", 32'(bytes_left), 0);
        dp_read(v);
        check("R6 resumed word", v, {8'(8'h13 + b0), 8'(8'h12 + b0), 8'(8'h11 + b0), 8'(8'h10 + b0)});

        // R8 overflow: 17 pushes with zero count
        card_rx_ready = 0;
        go(1'b0);
        set_blk(0);
        for (int i = 0; i < 17; i++) dp_write(32'(i + 1));
        tick(2);
        check("R8 R9 full level", 32'(dbg_q[8:4]), 16);
        begin
            int bad = 0;
            for (int i = 0; i < 16; i++) begin
                dp_read(v);
                if (v !== 32'(i + 1)) bad++;
            end
            check("R8 fifo order", 32'(bad), 0);
        end
        dp_read(v);
        check("R8 dropped push", v, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule